// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Burst SRAM

This block is a synthesizable model of a synchronous single-port static RAM. It accepts a fresh command on every enabled rising clock edge: read, write or deselect. It does this with no idle cycle when the bus changes direction. The array is 32 bits wide, split into four byte lanes, and its depth is set by a parameter. Address, control and byte enables are registered with the command. The write data for a command is sampled on the following enabled edge. Read data flows straight from the array to the output with no output register, so it appears in the cycle right after the edge that registered the read.

A command is either a load or an advance. A load takes a new external address and starts a new read, write or deselect. An advance keeps the previous command type and steps a 2-bit beat counter. The counter moves the two low address bits in either linear or interleaved order, and the order is chosen at load time. An active-low clock enable freezes the whole block. Three chip selects must all be active on a load for the device to be selected. Tristate pins, electrical timing and power-down behaviour are not modelled.

Top module: `nws_burst_ram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the command state is cleared to deselect with beat counter 0. After reset `rvalid` is 0 and `rdata` is 0. The array contents are not cleared.
- R2: When `clk_en_n` is 1 at a rising edge, every other synchronous input is ignored. No state changes, no array write happens, and `rdata`/`rvalid` hold their values.
- R3: `advance`=0 loads `addr`, `interleave` and a new command decoded from the selects and `rd_wr_n`. `advance`=1 keeps the previous command type, base address and order, increments the beat counter, and ignores `addr`, `rd_wr_n`, the selects and `interleave`.
- R4: In linear order (`interleave`=0 at load), beat k uses low address bits (start + k) mod 4. Address bits above bit 1 never change during a burst.
- R5: In interleaved order (`interleave`=1 at load), beat k uses low address bits start XOR (k mod 4).
- R6: `lane_we_n[i]`=0 enables byte lane i (data bits 8i+7..8i) for the write beat it is registered with. Lanes with `lane_we_n[i]`=1 keep their old contents.
- R7: The write data for a write beat registered at one enabled edge is taken from `wdata` at the next enabled edge. `wdata` presented together with the command is not stored.
- R8: For a read beat registered at an edge, `rvalid` is 1 and `rdata` shows the word at the beat address before the next edge.
- R9: Commands may alternate between read and write on consecutive edges with no idle cycle. A read registered on the edge that completes a write to the same address returns the newly written bytes.
- R10: A load is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Otherwise it is a deselect: `rvalid`=0, `rdata`=0, and no array write follows, including on later advance beats.
- R11: `rvalid` is 0 and `rdata` is 0 during write and deselect beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| advance | input | 1 | 1 = next burst beat, 0 = load new address and command |
| rd_wr_n | input | 1 | Command select on load: 1 read, 0 write |
| lane_we_n | input | 4 | Active-low byte lane write enables, registered per beat |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| interleave | input | 1 | Burst order on load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address, used on load |
| wdata | input | DATA_W | Write data for the beat registered one enabled edge earlier |
| rdata | output | DATA_W | Flow-through read data, 0 when not valid |
| rvalid | output | 1 | 1 during selected read beats |

## Verification
The bench aims at the turnaround corners. A read of an address on the edge that completes its write must see the new bytes; a design that lagged the write by one cycle would return stale data there. Write data offered together with the command must be discarded; a design that captured it would store it. Stalls inside a burst must freeze both the beat counter and a pending write, otherwise the design would skip beats or store the stalled data. Bursts start at every low-bit offset in both orders, including the wrap after beat 3, and deselected loads are followed by advances with good selects, which a design that re-sampled the selects would turn into live accesses.

// File: rtl/nws_pkg.sv
// Package: shared command encoding and burst address arithmetic for the
// flow-through burst RAM. Assumes a 2-bit beat counter.
package nws_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // Low two address bits for a beat, linear (sum) or interleaved (xor).
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       il);
        logic [1:0] sum;
        sum = start + step;
        return il ? (start ^ step) : sum;
    endfunction

endpackage

// File: rtl/nws_cmd_stage.sv
// Module: command register of the burst RAM. Holds the command type, base
// address, burst order, per-beat lane enables and the 2-bit beat counter.
// Assumes the caller decodes the command; stall freezes everything.
module nws_cmd_stage
    import nws_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              load,
    input  cmd_e              new_cmd,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic              new_il,
    input  logic [LANES-1:0]  new_lane_en,
    output cmd_e              cmd_q,
    output logic [ADDR_W-1:0] base_q,
    output logic              il_q,
    output logic [1:0]        step_q,
    output logic [LANES-1:0]  lane_en_q
);

    // Register a new command on load, step the beat counter on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_DESEL;
            base_q    <= '0;
            il_q      <= 1'b0;
            step_q    <= 2'd0;
            lane_en_q <= '0;
        end else if (!stall) begin
            lane_en_q <= new_lane_en;
            if (load) begin
                cmd_q  <= new_cmd;
                base_q <= new_addr;
                il_q   <= new_il;
                step_q <= 2'd0;
            end else begin
                step_q <= step_q + 2'd1;
            end
        end
    end

    // A stalled edge leaves every command field unchanged.
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && stall) |=> ($stable(cmd_q) && $stable(base_q) && $stable(step_q)
                              && $stable(il_q) && $stable(lane_en_q)));

    // An advance steps the counter and keeps the command type and base.
    assert_adv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && !load) |=> (step_q == $past(step_q) + 2'd1
                                        && cmd_q == $past(cmd_q)
                                        && base_q == $past(base_q)));

    // A load restarts the counter at beat 0.
    assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && load) |=> (step_q == 2'd0));

endmodule

// File: rtl/nws_beat_addr.sv
// Module: forms the word address of the current beat from the base address
// and beat counter. Only the two low bits move; the rest pass through.
// Assumes ADDR_W >= 3.
module nws_beat_addr
    import nws_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        step,
    input  logic              il,
    output logic [ADDR_W-1:0] beat_addr
);

    // Combine the fixed upper bits with the sequenced low bits.
    always_comb begin
        beat_addr = {base[ADDR_W-1:2], beat_low(base[1:0], step, il)};
    end

endmodule

// File: rtl/nws_lane_store.sv
// Module: one byte lane of the storage array, with one write port and one
// asynchronous read port. Contents are not reset. Assumes a read and a
// write to the same word at one edge shows the new byte after that edge.
module nws_lane_store #(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wbyte,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rbyte
);

    logic [7:0] cells [DEPTH];

    // Store one byte when this lane is enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wbyte;
        end
    end

    // Flow-through read of the addressed byte.
    assign rbyte = cells[raddr];

endmodule

// File: rtl/nws_burst_ram.sv
// Module: top of the flow-through zero-turnaround burst RAM. Decodes the
// command on load, keeps it in the command stage, sequences the beat
// address and drives the byte lanes. Write data comes one enabled edge
// after its command; read data is combinational from the array.
// Assumes DATA_W is a multiple of 8.
module nws_burst_ram
    import nws_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              advance,
    input  logic              rd_wr_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    cmd_e              new_cmd;
    cmd_e              cmd_q;
    logic [ADDR_W-1:0] base_q;
    logic              il_q;
    logic [1:0]        step_q;
    logic [LANES-1:0]  lane_en_q;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] word;
    logic              commit;

    // Decode the command presented with a load.
    always_comb begin
        if (sel0_n || !sel1 || sel2_n) begin
            new_cmd = CMD_DESEL;
        end else if (rd_wr_n) begin
            new_cmd = CMD_READ;
        end else begin
            new_cmd = CMD_WRITE;
        end
    end

    nws_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (clk_en_n),
        .load        (!advance),
        .new_cmd     (new_cmd),
        .new_addr    (addr),
        .new_il      (interleave),
        .new_lane_en (~lane_we_n),
        .cmd_q       (cmd_q),
        .base_q      (base_q),
        .il_q        (il_q),
        .step_q      (step_q),
        .lane_en_q   (lane_en_q)
    );

    nws_beat_addr #(.ADDR_W(ADDR_W)) u_seq (
        .base      (base_q),
        .step      (step_q),
        .il        (il_q),
        .beat_addr (beat_addr)
    );

    // A registered write beat completes on the next enabled edge.
    assign commit = rst_n && !clk_en_n && (cmd_q == CMD_WRITE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nws_lane_store #(.ADDR_W(ADDR_W)) u_lane (
            .clk   (clk),
            .we    (commit && lane_en_q[g]),
            .waddr (beat_addr),
            .wbyte (wdata[8*g +: 8]),
            .raddr (beat_addr),
            .rbyte (word[8*g +: 8])
        );
    end

    // Present read data only for selected read beats.
    always_comb begin
        rvalid = (cmd_q == CMD_READ);
        rdata  = rvalid ? word : '0;
    end

    // A stalled edge leaves the outputs unchanged.
    assert_stall_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en_n) |=> ($stable(rdata) && $stable(rvalid)));

    // Upper address bits are fixed within a burst.
    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en_n && advance) |=>
            (beat_addr[ADDR_W-1:2] == $past(beat_addr[ADDR_W-1:2])));

    // Linear order steps the low bits by one per beat.
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en_n && advance && !il_q) |=>
            (beat_addr[1:0] == $past(beat_addr[1:0]) + 2'd1));

    // Interleaved order: low bits XOR start equals the beat index.
    assert_il_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en_n && advance && il_q) |=>
            ((beat_addr[1:0] ^ $past(base_q[1:0])) == $past(step_q) + 2'd1));

    // A write load never shows valid read data.
    assert_write_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en_n && !advance && !rd_wr_n) |=> !rvalid);

    // A load with an inactive select is a deselect.
    assert_desel_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en_n && !advance && (sel0_n || !sel1 || sel2_n)) |=> !rvalid);

endmodule

// File: tb/nws_burst_ram_tb.sv
module nws_burst_ram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          advance = 1'b0;
    logic          rd_wr_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          sel0_n = 1'b1;
    logic          sel1 = 1'b0;
    logic          sel2_n = 1'b1;
    logic          interleave = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int n_checks = 0;
    int n_errors = 0;

    // reference state
    logic [DW-1:0] ref_mem [256];
    int            m_op = 0;          // 0 deselect, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = 2'd0;
    bit            m_il = 1'b0;
    logic [3:0]    m_lanes = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nws_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance),
        .rd_wr_n(rd_wr_n), .lane_we_n(lane_we_n), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .interleave(interleave), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [AW-1:0] ref_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [3:0] en);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < 4; i++) if (en[i]) r[8*i +: 8] = new_w[8*i +: 8];
        return r;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare both outputs against the reference model
    task automatic check_out(input string tag);
        logic          ev;
        logic [DW-1:0] ed;
        ev = (m_op == 1);
        ed = ev ? ref_mem[ref_addr()] : '0;
        check({tag, " rvalid"}, {31'd0, rvalid}, {31'd0, ev});
        check({tag, " rdata"}, rdata, ed);
    endtask

    // apply inputs for one cycle, update the model at the edge, check after
    task automatic cyc(input string tag, input bit cen_n, input bit adv, input bit rw_n,
                       input logic [3:0] bwn, input bit s0n, input bit s1, input bit s2n,
                       input bit il, input logic [AW-1:0] a, input logic [DW-1:0] d);
        clk_en_n = cen_n; advance = adv; rd_wr_n = rw_n; lane_we_n = bwn;
        sel0_n = s0n; sel1 = s1; sel2_n = s2n; interleave = il; addr = a; wdata = d;
        @(posedge clk);
        if (!cen_n) begin
            if (m_op == 2) ref_mem[ref_addr()] = merge(ref_mem[ref_addr()], d, m_lanes);
            m_lanes = ~bwn;
            if (!adv) begin
                m_op = (s0n || !s1 || s2n) ? 0 : (rw_n ? 1 : 2);
                m_base = a; m_il = il; m_step = 2'd0;
            end else begin
                m_step = m_step + 2'd1;
            end
        end
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic ld(input string tag, input bit rw_n, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit il);
        cyc(tag, 1'b0, 1'b0, rw_n, 4'h0, 1'b0, 1'b1, 1'b0, il, a, d);
    endtask

    task automatic adv1(input string tag, input logic [DW-1:0] d);
        cyc(tag, 1'b0, 1'b1, $urandom_range(0, 1), 4'h0, 1'b1, 1'b0, 1'b1,
            $urandom_range(0, 1), AW'($urandom_range(0, 255)), d);
    endtask

    task automatic idle(input string tag, input logic [DW-1:0] d);
        cyc(tag, 1'b0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, '0, d);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_out("R1 after reset");
        check("R1 rdata zero", rdata, '0);

        // fill words 0..63, data for each beat arrives one cycle later
        for (int a = 0; a < 64; a++) ld("R11 fill", 1'b0, AW'(a), $urandom(), 1'b0);
        idle("R7 fill end", $urandom());

        // R9: write then read same word with no gap, then write after read
        ld("R11 write", 1'b0, 8'd5, 32'hDEAD_0000, 1'b0);
        ld("R9 read after write", 1'b1, 8'd5, 32'hCAFE_F00D, 1'b0);
        ld("R9 write after read", 1'b0, 8'd6, 32'h1111_2222, 1'b0);
        ld("R9 read new", 1'b1, 8'd6, 32'h3333_4444, 1'b0);

        // R7: data offered with the command is discarded
        ld("R7 write cmd", 1'b0, 8'd7, 32'hAAAA_AAAA, 1'b0);
        idle("R7 data beat", 32'h0000_1234);
        ld("R7 readback", 1'b1, 8'd7, 32'h5555_5555, 1'b0);

        // R6: only lanes 0 and 2 written
        cyc("R6 write cmd", 1'b0, 1'b0, 1'b0, 4'b1010, 1'b0, 1'b1, 1'b0, 1'b0, 8'd8, '0);
        idle("R6 data beat", 32'hFFFF_FFFF);
        ld("R6 readback", 1'b1, 8'd8, '0, 1'b0);

        // R4: linear bursts from every start offset, including wrap
        for (int s = 0; s < 4; s++) begin
            ld("R4 linear load", 1'b1, AW'(16 + s), '0, 1'b0);
            for (int k = 0; k < 4; k++) adv1("R4 linear beat R3", '0);
        end
        // R5: interleaved bursts from every start offset
        for (int s = 0; s < 4; s++) begin
            ld("R5 interleave load", 1'b1, AW'(20 + s), '0, 1'b1);
            for (int k = 0; k < 4; k++) adv1("R5 interleave beat", '0);
        end
        // R5: interleaved write burst then read back
        ld("R5 write load", 1'b0, 8'd26, '0, 1'b1);
        for (int k = 0; k < 3; k++) adv1("R5 write beat", $urandom());
        idle("R5 last data", $urandom());
        ld("R5 read back", 1'b1, 8'd24, '0, 1'b0);
        for (int k = 0; k < 3; k++) adv1("R5 read beat", '0);

        // R2: stall holds read output and ignores a new load
        ld("R2 read", 1'b1, 8'd9, '0, 1'b0);
        cyc("R2 stalled", 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 32'hBAD0_BAD0);
        // R2: stall inside a write keeps the pending write
        ld("R2 write", 1'b0, 8'd11, '0, 1'b0);
        cyc("R2 stall write", 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 32'hBAD1_BAD1);
        idle("R2 data beat", 32'h0000_0055);
        ld("R2 readback", 1'b1, 8'd11, '0, 1'b0);

        // R10: each inactive select gives a deselect
        cyc("R10 sel0", 1'b0, 1'b0, 1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd12, '0);
        cyc("R10 sel1", 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12, '0);
        cyc("R10 sel2", 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd12, '0);
        // R10: deselected write, advance with good selects stays deselect
        cyc("R10 desel write", 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd12, '0);
        cyc("R10 desel adv", 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 32'hBAD2_BAD2);
        idle("R10 after", 32'hBAD3_BAD3);
        ld("R10 readback", 1'b1, 8'd12, '0, 1'b0);
        ld("R10 readback2", 1'b1, 8'd13, '0, 1'b0);

        // R11: write beats inside a write burst show no valid data
        ld("R11 write burst", 1'b0, 8'd30, '0, 1'b0);
        adv1("R11 write beat", $urandom());
        idle("R11 end", $urandom());

        // constrained random traffic over the initialised words
        for (int n = 0; n < 4000; n++) begin
            bit            cen_n, adv, rw_n, bad;
            logic [3:0]    bwn;
            string         tag;
            cen_n = ($urandom_range(0, 9) == 0);
            adv   = ($urandom_range(0, 1) == 1);
            rw_n  = ($urandom_range(0, 1) == 1);
            bad   = ($urandom_range(0, 7) == 0);
            bwn   = 4'($urandom_range(0, 15));
            tag   = (m_op == 1) ? "R8 random" : ((m_op == 2) ? "R11 random" : "R10 random");
            cyc(tag, cen_n, adv, rw_n, bwn, bad, 1'b1, 1'b0,
                $urandom_range(0, 1), AW'($urandom_range(0, 63)), $urandom());
        end

        report();
    end
endmodule